// File: doc/BRIEF.md
# Receive frame accept filter

This block makes the final keep-or-drop decision for each frame that a receive MAC has finished taking in. On a single end-of-frame strobe it combines the destination-address class, the result of the address-table lookup, the frame's error flags, the received byte count and the port configuration. One cycle later it raises exactly one of two pulses, accept or drop, and presents a registered status word and an error-summary bit for the descriptor writer that follows it.

The address-table lookup runs ahead of the end of the frame and reports on a valid-qualified port. The block holds that result until the frame closes. A frame that closes with no lookup reported is treated as a table miss. The length check classifies the byte count, CRC included, against a 64-byte minimum and a maximum chosen by a 2-bit code. The hash walk, the CRC calculation and the DMA writes belong to other blocks.

Top module: `rxf_accept_filter`

## Requirements
- R1: After reset, accept_pulse and drop_pulse are 0, status_word is 0 and err_sum is 0.
- R2: The cycle after eof_valid is high, exactly one of accept_pulse and drop_pulse is high. In any cycle not preceded by eof_valid, both are low.
- R3: With promiscuous mode off, a table hit whose receive bit (lkp_rcv) is 1 accepts the frame, and a hit whose receive bit is 0 drops it.
- R4: With promiscuous mode off, a table miss accepts the frame when cfg_miss_pass is 1 and drops it when it is 0. A frame that closes with no lookup reported counts as a miss.
- R5: With cfg_rej_bcast set and promiscuous mode off, a broadcast frame (da_class = 2'b10) is dropped whatever the lookup says. With promiscuous mode on, the rejection has no effect. Unicast (2'b00) and multicast (2'b01) frames are not affected by cfg_rej_bcast.
- R6: With cfg_promisc set, the address check always passes: misses and discard hits are accepted, provided the frame is error-free or cfg_pass_bad is set.
- R7: A frame with err_sum set is dropped unless cfg_pass_bad is 1. With cfg_pass_bad set, it is accepted only if it passes the address check.
- R8: A frame_len below 64 sets the short-frame bit (status bit 5). A frame_len of 64 does not.
- R9: frame_len above the limit chosen by cfg_maxlen_sel sets the too-long bit (status bit 4). The limits are 0 -> 1518, 1 -> 1536, 2 -> 2048 and 3 -> 65536 bytes, and a length equal to the limit is not too long.
- R10: Status bits are: 0 CRC error, 1 collision, 2 late collision, 3 overrun, 4 too long, 5 short, 7:6 da_class, 8 lookup hit, and 15 error summary. All other bits are 0. The error summary, also driven on err_sum, is the OR of bits 0 to 5.
- R11: When cfg_en is 0 at eof_valid, the frame is dropped and status_word and err_sum are 0.
- R12: A lookup result is used for one frame only. It is cleared at that frame's eof_valid, so a later frame with no new lookup is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Port enable |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_rej_bcast | input | 1 | Reject broadcast frames |
| cfg_pass_bad | input | 1 | Deliver errored frames that pass the address check |
| cfg_miss_pass | input | 1 | Default for a table miss: 1 accept, 0 drop |
| cfg_maxlen_sel | input | 2 | Maximum length code |
| lkp_valid | input | 1 | Lookup result valid |
| lkp_hit | input | 1 | Destination address found in the table |
| lkp_rcv | input | 1 | Receive bit of the matching entry |
| eof_valid | input | 1 | End-of-frame strobe that qualifies the frame inputs |
| da_class | input | 2 | 00 unicast, 01 multicast, 10 broadcast |
| frame_len | input | LEN_W | Received byte count, CRC included |
| err_crc | input | 1 | CRC error |
| err_col | input | 1 | Collision during reception |
| err_late_col | input | 1 | Late collision |
| err_ovr | input | 1 | Overrun |
| accept_pulse | output | 1 | Frame goes to host |
| drop_pulse | output | 1 | Frame discarded |
| err_sum | output | 1 | Error summary of the last frame |
| status_word | output | 16 | Status of the last frame |

## Verification
The assertions check on every cycle the pulse discipline: one outcome per end-of-frame strobe and no pulse without one. They also check that a disabled port always drops with an empty status, that broadcast rejection drops outside promiscuous mode, that an accepted errored frame implies pass-bad was set, and that a held lookup is cleared once its frame closes. The scenarios alone show the decision matrix: hit with receive, hit with discard, the miss default, promiscuous overrides, and pass-bad limited to address-passing frames. They also show the exact length limits on both sides of each code's boundary and the placement of each status bit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int unsigned STAT_W = 16;

   localparam int unsigned ST_CRC   = 0;
   localparam int unsigned ST_COL   = 1;
   localparam int unsigned ST_LATE  = 2;
   localparam int unsigned ST_OVR   = 3;
   localparam int unsigned ST_LONG  = 4;
   localparam int unsigned ST_SHORT = 5;
   localparam int unsigned ST_DA_LO = 6;
   localparam int unsigned ST_HIT   = 8;
   localparam int unsigned ST_SUM   = 15;

   localparam int unsigned DEF_MIN_LEN = 64;
   localparam int unsigned DEF_MAX0    = 1518;
   localparam int unsigned DEF_MAX1    = 1536;
   localparam int unsigned DEF_MAX2    = 2048;
   localparam int unsigned DEF_MAX3    = 65536;

   typedef enum logic [1:0] {
      DA_UCAST = 2'b00,
      DA_MCAST = 2'b01,
      DA_BCAST = 2'b10,
      DA_RSVD  = 2'b11
   } da_class_e;

   typedef struct packed {
      logic ovr;
      logic late;
      logic col;
      logic crc;
   } rx_err_t;
endpackage

// File: rtl/rxf_len_check.sv
module rxf_len_check #(
   parameter int unsigned LEN_W   = 17,
   parameter int unsigned MIN_LEN = rxf_pkg::DEF_MIN_LEN,
   parameter int unsigned MAX0    = rxf_pkg::DEF_MAX0,
   parameter int unsigned MAX1    = rxf_pkg::DEF_MAX1,
   parameter int unsigned MAX2    = rxf_pkg::DEF_MAX2,
   parameter int unsigned MAX3    = rxf_pkg::DEF_MAX3
) (
   input  logic [LEN_W-1:0] len,
   input  logic [1:0]       sel,
   output logic             too_short,
   output logic             too_long
);
   localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] LIM0  = LEN_W'(MAX0);
   localparam logic [LEN_W-1:0] LIM1  = LEN_W'(MAX1);
   localparam logic [LEN_W-1:0] LIM2  = LEN_W'(MAX2);
   localparam logic [LEN_W-1:0] LIM3  = LEN_W'(MAX3);

   if (MAX3 >= (64'd1 << LEN_W)) begin : g_bad_width
      $error("rxf_len_check: LEN_W too narrow for largest limit");
   end
   if (MAX0 <= MIN_LEN || MAX1 <= MIN_LEN || MAX2 <= MIN_LEN || MAX3 <= MIN_LEN) begin : g_bad_lim
      $error("rxf_len_check: every limit must exceed the minimum");
   end

   logic [LEN_W-1:0] limit;

   always_comb begin
      unique case (sel)
         2'd0:    limit = LIM0;
         2'd1:    limit = LIM1;
         2'd2:    limit = LIM2;
         default: limit = LIM3;
      endcase
   end

   assign too_short = (len < MIN_V);
   assign too_long  = (len > limit);
endmodule

// File: rtl/rxf_lookup_hold.sv
module rxf_lookup_hold #(
   parameter bit SAME_CYCLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lkp_valid,
   input  logic lkp_hit,
   input  logic lkp_rcv,
   input  logic eof_valid,
   output logic hit_eff,
   output logic rcv_eff
);
   logic held_v, held_hit, held_rcv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v   <= 1'b0;
         held_hit <= 1'b0;
         held_rcv <= 1'b0;
      end else if (eof_valid) begin
         held_v   <= 1'b0;
         held_hit <= 1'b0;
         held_rcv <= 1'b0;
      end else if (lkp_valid) begin
         held_v   <= 1'b1;
         held_hit <= lkp_hit;
         held_rcv <= lkp_rcv;
      end
   end

   if (SAME_CYCLE) begin : g_bypass
      assign hit_eff = lkp_valid ? lkp_hit : (held_v & held_hit);
      assign rcv_eff = lkp_valid ? lkp_rcv : (held_v & held_rcv);
   end else begin : g_held
      assign hit_eff = held_v & held_hit;
      assign rcv_eff = held_v & held_rcv;
   end

   // R12: a held result never survives its frame's end
   a_r12_cleared_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> !held_v);
endmodule

// File: rtl/rxf_addr_gate.sv
module rxf_addr_gate (
   input  logic       promisc,
   input  logic       rej_bcast,
   input  logic       miss_pass,
   input  logic [1:0] da,
   input  logic       hit,
   input  logic       rcv,
   output logic       addr_ok
);
   import rxf_pkg::*;

   logic is_bcast;
   assign is_bcast = (da == DA_BCAST);

   always_comb begin
      if (promisc)
         addr_ok = 1'b1;
      else if (is_bcast && rej_bcast)
         addr_ok = 1'b0;
      else if (hit)
         addr_ok = rcv;
      else
         addr_ok = miss_pass;
   end
endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter #(
   parameter int unsigned LEN_W      = 17,
   parameter int unsigned MIN_LEN    = rxf_pkg::DEF_MIN_LEN,
   parameter int unsigned MAX0       = rxf_pkg::DEF_MAX0,
   parameter int unsigned MAX1       = rxf_pkg::DEF_MAX1,
   parameter int unsigned MAX2       = rxf_pkg::DEF_MAX2,
   parameter int unsigned MAX3       = rxf_pkg::DEF_MAX3,
   parameter bit          SAME_CYCLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_promisc,
   input  logic             cfg_rej_bcast,
   input  logic             cfg_pass_bad,
   input  logic             cfg_miss_pass,
   input  logic [1:0]       cfg_maxlen_sel,
   input  logic             lkp_valid,
   input  logic             lkp_hit,
   input  logic             lkp_rcv,
   input  logic             eof_valid,
   input  logic [1:0]       da_class,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             err_crc,
   input  logic             err_col,
   input  logic             err_late_col,
   input  logic             err_ovr,
   output logic             accept_pulse,
   output logic             drop_pulse,
   output logic             err_sum,
   output logic [15:0]      status_word
);
   import rxf_pkg::*;

   if (STAT_W != 16) begin : g_bad_stat
      $error("rxf_accept_filter: status width must be 16");
   end

   logic    hit_eff, rcv_eff, addr_ok, too_short, too_long, sum_n, take;
   rx_err_t errs;
   logic [STAT_W-1:0] stat_n;

   assign errs = '{ovr: err_ovr, late: err_late_col, col: err_col, crc: err_crc};

   rxf_lookup_hold #(.SAME_CYCLE(SAME_CYCLE)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .lkp_valid (lkp_valid),
      .lkp_hit   (lkp_hit),
      .lkp_rcv   (lkp_rcv),
      .eof_valid (eof_valid),
      .hit_eff   (hit_eff),
      .rcv_eff   (rcv_eff)
   );

   rxf_len_check #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN),
      .MAX0(MAX0), .MAX1(MAX1), .MAX2(MAX2), .MAX3(MAX3)
   ) u_len (
      .len       (frame_len),
      .sel       (cfg_maxlen_sel),
      .too_short (too_short),
      .too_long  (too_long)
   );

   rxf_addr_gate u_addr (
      .promisc   (cfg_promisc),
      .rej_bcast (cfg_rej_bcast),
      .miss_pass (cfg_miss_pass),
      .da        (da_class),
      .hit       (hit_eff),
      .rcv       (rcv_eff),
      .addr_ok   (addr_ok)
   );

   assign sum_n = |errs | too_long | too_short;
   assign take  = cfg_en & addr_ok & (~sum_n | cfg_pass_bad);

   always_comb begin
      stat_n                        = '0;
      stat_n[ST_CRC]                = errs.crc;
      stat_n[ST_COL]                = errs.col;
      stat_n[ST_LATE]               = errs.late;
      stat_n[ST_OVR]                = errs.ovr;
      stat_n[ST_LONG]               = too_long;
      stat_n[ST_SHORT]              = too_short;
      stat_n[ST_DA_LO +: 2]         = da_class;
      stat_n[ST_HIT]                = hit_eff;
      stat_n[ST_SUM]                = sum_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept_pulse <= 1'b0;
         drop_pulse   <= 1'b0;
         status_word  <= '0;
         err_sum      <= 1'b0;
      end else begin
         accept_pulse <= eof_valid & take;
         drop_pulse   <= eof_valid & ~take;
         if (eof_valid) begin
            status_word <= cfg_en ? stat_n : '0;
            err_sum     <= cfg_en & sum_n;
         end
      end
   end

   // R2: one outcome per strobe
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> (accept_pulse ^ drop_pulse));
   // R2: no pulse without a strobe
   a_r2_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_valid |=> (!accept_pulse && !drop_pulse));
   // R11: disabled port drops with empty status
   a_r11_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && !cfg_en) |=> (drop_pulse && status_word == '0 && !err_sum));
   // R5: broadcast rejection outside promiscuous mode
   a_r5_bcast_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && !cfg_promisc && cfg_rej_bcast && da_class == 2'b10) |=> drop_pulse);
   // R7: an errored frame reaches the host only with pass-bad set
   a_r7_bad_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_pulse && err_sum) |-> $past(cfg_pass_bad));
endmodule

// File: tb/rxf_accept_filter_bench.sv
module rxf_accept_filter_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en, cfg_promisc, cfg_rej_bcast, cfg_pass_bad, cfg_miss_pass;
   logic [1:0] cfg_maxlen_sel;
   logic lkp_valid, lkp_hit, lkp_rcv, eof_valid;
   logic [1:0] da_class;
   logic [16:0] frame_len;
   logic err_crc, err_col, err_late_col, err_ovr;
   logic accept_pulse, drop_pulse, err_sum;
   logic [15:0] status_word;

   int errors = 0;
   int checks = 0;
   logic s_acc, s_drop, s_err;
   logic [15:0] s_st;

   always #10 clk = ~clk;

   rxf_accept_filter u_rxf_accept_filter (
      .clk(clk), .rst_n(rst_n),
      .cfg_en(cfg_en), .cfg_promisc(cfg_promisc), .cfg_rej_bcast(cfg_rej_bcast),
      .cfg_pass_bad(cfg_pass_bad), .cfg_miss_pass(cfg_miss_pass),
      .cfg_maxlen_sel(cfg_maxlen_sel),
      .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .lkp_rcv(lkp_rcv),
      .eof_valid(eof_valid), .da_class(da_class), .frame_len(frame_len),
      .err_crc(err_crc), .err_col(err_col), .err_late_col(err_late_col), .err_ovr(err_ovr),
      .accept_pulse(accept_pulse), .drop_pulse(drop_pulse),
      .err_sum(err_sum), .status_word(status_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic en, input logic pr, input logic rb,
                      input logic pb, input logic mp, input logic [1:0] sel);
      cfg_en = en; cfg_promisc = pr; cfg_rej_bcast = rb;
      cfg_pass_bad = pb; cfg_miss_pass = mp; cfg_maxlen_sel = sel;
   endtask

   // errs: bit0 crc, bit1 collision, bit2 late collision, bit3 overrun
   task automatic send(input logic [1:0] da, input logic lv, input logic hit,
                       input logic rcv, input logic [16:0] len, input logic [3:0] errs);
      if (lv) begin
         lkp_valid = 1'b1; lkp_hit = hit; lkp_rcv = rcv;
         @(negedge clk);
         lkp_valid = 1'b0; lkp_hit = 1'b0; lkp_rcv = 1'b0;
      end
      da_class = da; frame_len = len;
      {err_ovr, err_late_col, err_col, err_crc} = errs;
      eof_valid = 1'b1;
      @(negedge clk);
      eof_valid = 1'b0;
      errs = 4'h0;
      {err_ovr, err_late_col, err_col, err_crc} = errs;
      s_acc = accept_pulse; s_drop = drop_pulse; s_st = status_word; s_err = err_sum;
   endtask

   task automatic t_reset;
      chk("R1 acc", accept_pulse, 0);
      chk("R1 drop", drop_pulse, 0);
      chk("R1 status", status_word, 0);
      chk("R1 errsum", err_sum, 0);
   endtask

   task automatic t_pulse;
      cfg(1, 0, 0, 0, 0, 0);
      send(2'b00, 1, 1, 1, 17'd100, 4'h0);
      chk("R2 one outcome", {s_acc, s_drop}, 2'b10);
      @(negedge clk);
      chk("R2 no stray pulse", {accept_pulse, drop_pulse}, 2'b00);
      chk("R2 status held", status_word, 16'h0100);
   endtask

   task automatic t_table;
      cfg(1, 0, 0, 0, 0, 0);
      send(2'b00, 1, 1, 1, 17'd200, 4'h0);
      chk("R3 hit receive", {s_acc, s_drop}, 2'b10);
      send(2'b01, 1, 1, 0, 17'd200, 4'h0);
      chk("R3 hit discard", {s_acc, s_drop}, 2'b01);
   endtask

   task automatic t_miss;
      cfg(1, 0, 0, 0, 0, 0);
      send(2'b00, 1, 0, 0, 17'd200, 4'h0);
      chk("R4 miss default drop", {s_acc, s_drop}, 2'b01);
      cfg(1, 0, 0, 0, 1, 0);
      send(2'b00, 1, 0, 0, 17'd200, 4'h0);
      chk("R4 miss default pass", {s_acc, s_drop}, 2'b10);
      send(2'b01, 0, 0, 0, 17'd200, 4'h0);
      chk("R4 no lookup is miss", {s_acc, s_drop}, 2'b10);
   endtask

   task automatic t_bcast;
      cfg(1, 0, 1, 0, 1, 0);
      send(2'b10, 1, 1, 1, 17'd80, 4'h0);
      chk("R5 bcast rejected", {s_acc, s_drop}, 2'b01);
      send(2'b01, 1, 1, 1, 17'd80, 4'h0);
      chk("R5 mcast unaffected", {s_acc, s_drop}, 2'b10);
      cfg(1, 1, 1, 0, 0, 0);
      send(2'b10, 0, 0, 0, 17'd80, 4'h0);
      chk("R5 promisc overrides", {s_acc, s_drop}, 2'b10);
   endtask

   task automatic t_promisc;
      cfg(1, 1, 0, 0, 0, 0);
      send(2'b00, 1, 1, 0, 17'd500, 4'h0);
      chk("R6 discard hit accepted", {s_acc, s_drop}, 2'b10);
      send(2'b00, 1, 0, 0, 17'd500, 4'h1);
      chk("R6 errored dropped", {s_acc, s_drop}, 2'b01);
      cfg(1, 1, 0, 1, 0, 0);
      send(2'b00, 1, 0, 0, 17'd500, 4'h1);
      chk("R6 errored with pass-bad", {s_acc, s_drop}, 2'b10);
   endtask

   task automatic t_passbad;
      cfg(1, 0, 0, 1, 0, 0);
      send(2'b00, 1, 1, 0, 17'd300, 4'h2);
      chk("R7 bad frame failing address", {s_acc, s_drop}, 2'b01);
      send(2'b00, 1, 1, 1, 17'd300, 4'h2);
      chk("R7 bad frame passing address", {s_acc, s_drop, s_err}, 3'b101);
      cfg(1, 0, 0, 0, 0, 0);
      send(2'b00, 1, 1, 1, 17'd300, 4'h2);
      chk("R7 bad frame no pass-bad", {s_acc, s_drop}, 2'b01);
   endtask

   task automatic t_len;
      cfg(1, 0, 0, 1, 1, 0);
      send(2'b00, 0, 0, 0, 17'd63, 4'h0);
      chk("R8 63 short", s_st[5], 1);
      send(2'b00, 0, 0, 0, 17'd64, 4'h0);
      chk("R8 64 not short", {s_st[5], s_err}, 2'b00);
      send(2'b00, 0, 0, 0, 17'd1518, 4'h0);
      chk("R9 code0 at limit", s_st[4], 0);
      send(2'b00, 0, 0, 0, 17'd1519, 4'h0);
      chk("R9 code0 over", {s_st[4], s_err}, 2'b11);
      cfg(1, 0, 0, 1, 1, 1);
      send(2'b00, 0, 0, 0, 17'd1536, 4'h0);
      chk("R9 code1 at limit", s_st[4], 0);
      send(2'b00, 0, 0, 0, 17'd1537, 4'h0);
      chk("R9 code1 over", s_st[4], 1);
      cfg(1, 0, 0, 1, 1, 2);
      send(2'b00, 0, 0, 0, 17'd2048, 4'h0);
      chk("R9 code2 at limit", s_st[4], 0);
      send(2'b00, 0, 0, 0, 17'd2049, 4'h0);
      chk("R9 code2 over", s_st[4], 1);
      cfg(1, 0, 0, 1, 1, 3);
      send(2'b00, 0, 0, 0, 17'd65536, 4'h0);
      chk("R9 code3 at limit", s_st[4], 0);
      send(2'b00, 0, 0, 0, 17'd65537, 4'h0);
      chk("R9 code3 over", s_st[4], 1);
   endtask

   task automatic t_errsum;
      cfg(1, 0, 0, 1, 1, 0);
      for (int i = 0; i < 4; i++) begin
         send(2'b00, 0, 0, 0, 17'd100, 4'(1 << i));
         chk("R10 flag bit and summary", s_st, 16'h8000 | (16'h1 << i));
         chk("R10 err_sum port", s_err, 1);
      end
      send(2'b10, 1, 1, 1, 17'd100, 4'h0);
      chk("R10 clean bcast layout", {s_st, s_err}, {16'h0180, 1'b0});
   endtask

   task automatic t_disable;
      cfg(0, 1, 0, 1, 1, 0);
      send(2'b00, 1, 1, 1, 17'd10, 4'h1);
      chk("R11 disabled drops", {s_acc, s_drop}, 2'b01);
      chk("R11 disabled status", {s_st, s_err}, 17'h0);
   endtask

   task automatic t_latch;
      cfg(1, 0, 0, 0, 0, 0);
      send(2'b00, 1, 1, 1, 17'd100, 4'h0);
      chk("R12 first frame uses hit", s_acc, 1);
      send(2'b00, 0, 0, 0, 17'd100, 4'h0);
      chk("R12 stale hit cleared", {s_acc, s_drop, s_st[8]}, 3'b010);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cfg(1, 0, 0, 0, 0, 0);
      lkp_valid = 0; lkp_hit = 0; lkp_rcv = 0; eof_valid = 0;
      da_class = 0; frame_len = 0;
      err_crc = 0; err_col = 0; err_late_col = 0; err_ovr = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pulse();
      t_table();
      t_miss();
      t_bcast();
      t_promisc();
      t_passbad();
      t_len();
      t_errsum();
      t_disable();
      t_latch();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule